// File: doc/BRIEF.md
# Codec Link Input-Frame Serializer

This block sits on the codec side of a two-wire AC'97-style audio link. It builds the serial frame that goes from the codec to the controller and shifts it out on one data line. It is clocked by the link bit clock. A rising edge on the sync input starts a frame of 256 bits. The frame is a 16-bit tag slot followed by twelve 20-bit slots, all sent most significant bit first.

When a frame starts, the block captures its inputs: the codec-ready flag, a pending register-read response (7-bit register index and 16-bit read data), and a left/right pair of 18-bit ADC samples with a shared valid flag. It formats these into slot words. The tag slot marks which slots hold live content. Each slot follows its own zero-stuffing rule, and every slot from 5 onwards is driven as zero. A read response rides in exactly one frame, and a one-cycle acknowledge tells the register side that the response has been taken.

Top module: `codec_frame_tx`

## Requirements
- R1: The bit clock edge that sees `sync` high after sampling it low is the frame start. Frame bit k (k = 0 for tag bit 15) is on `sdata` during the k-th bit clock period after that edge. After 256 bits, `sdata` stays 0 until the next sync rise. A sync rise during a frame abandons that frame and starts a new one.
- R2: Tag bit 15 (frame bit 0) equals `codec_ready` as captured at frame start.
- R3: Tag bits 14 and 13 (slots 1 and 2 valid) both equal the captured `rd_pending`. Tag bits 12 and 11 (slots 3 and 4 valid) both equal the captured `adc_valid`. Tag bits 10:0 are 0.
- R4: Slot 1, when `rd_pending` was captured high, is bit 19 = 0, bits 18:12 = `rd_index`, and bits 11:0 = 0. Otherwise all 20 bits are 0.
- R5: Slot 2, when `rd_pending` was captured high, is bits 19:4 = `rd_data` and bits 3:0 = 0. Otherwise all 20 bits are 0. It always belongs to the same frame as the slot-1 index.
- R6: Slots 3 and 4 carry `adc_left` and `adc_right` in bits 19:2, with bits 1:0 = 0. When `adc_valid` was captured low, both slots are all zero.
- R7: Slots 5 through 12 are always all zero.
- R8: Input changes after the frame-start edge have no effect on the frame in progress.
- R9: `rd_ack` is high for exactly the one bit clock period after a frame start that captured `rd_pending` high, and is low at all other times.
- R10: While `rst_n` is low, and after reset until the first sync rise, `sdata` and `rd_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync; its rising edge starts a frame |
| codec_ready | input | 1 | Codec ready flag for tag bit 15 |
| rd_pending | input | 1 | A register-read response is waiting to be sent |
| rd_index | input | 7 | Register index being answered |
| rd_data | input | 16 | Register read data |
| adc_valid | input | 1 | Left/right samples are valid |
| adc_left | input | 18 | Left ADC sample |
| adc_right | input | 18 | Right ADC sample |
| sdata | output | 1 | Serial frame data, MSB first |
| rd_ack | output | 1 | One-cycle pulse: the pending response was taken into a frame |

## Verification
The hardest case to reach from the ports is a sync rise that arrives in the middle of a frame. The counter has to give up the remaining bits and rewind to the tag, and the new contents have to be captured. The stimulus builds this case by cutting a frame short after 120 bits, then raising sync with new inputs while the old frame is still shifting out, and checking every bit of the new frame. A second hard case is an input change in the middle of a frame. The stimulus inverts every input partway through some frames and still expects the bits captured at the start.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int DATA_SLOTS = 4;
  localparam int SLOT_NUM_W = $clog2(NUM_SLOTS + 1);
  localparam int POS_W      = $clog2(SLOT_W);
  localparam int TAG_POS_W  = $clog2(TAG_W);

  typedef logic [SLOT_NUM_W-1:0] slot_num_t;
  typedef logic [POS_W-1:0]      bit_pos_t;
  typedef logic [SLOT_W-1:0]     slot_word_t;
  typedef logic [TAG_W-1:0]      tag_word_t;

  localparam slot_num_t LAST_SLOT  = slot_num_t'(NUM_SLOTS);
  localparam slot_num_t SLOT_ADDR  = slot_num_t'(1);
  localparam slot_num_t SLOT_DATA  = slot_num_t'(2);
  localparam slot_num_t SLOT_LEFT  = slot_num_t'(3);
  localparam slot_num_t SLOT_RIGHT = slot_num_t'(4);
  localparam bit_pos_t  TAG_TOP    = bit_pos_t'(TAG_W - 1);
  localparam bit_pos_t  SLOT_TOP   = bit_pos_t'(SLOT_W - 1);
endpackage

// File: rtl/cfx_frame_timer.sv
module cfx_frame_timer
  import cfx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync,
  output logic      frame_start,
  output logic      frame_last,
  output logic      active,
  output slot_num_t slot_num,
  output bit_pos_t  bit_pos
);
  logic sync_q;

  assign frame_start = sync & ~sync_q;
  assign frame_last  = active && (slot_num == LAST_SLOT) && (bit_pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active   <= 1'b0;
      slot_num <= '0;
      bit_pos  <= '0;
    end else begin
      sync_q <= sync;
      if (frame_start) begin
        active   <= 1'b1;
        slot_num <= '0;
        bit_pos  <= TAG_TOP;
      end else if (active) begin
        if (bit_pos == '0) begin
          if (slot_num == LAST_SLOT) begin
            active <= 1'b0;
          end else begin
            slot_num <= slot_num + slot_num_t'(1);
            bit_pos  <= SLOT_TOP;
          end
        end else begin
          bit_pos <= bit_pos - bit_pos_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cfx_slot_latch.sv
module cfx_slot_latch
  import cfx_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int RD_W  = 16,
  parameter int ADC_W = 18
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  frame_start,
  input  logic                                  codec_ready,
  input  logic                                  rd_pending,
  input  logic [IDX_W-1:0]                      rd_index,
  input  logic [RD_W-1:0]                       rd_data,
  input  logic                                  adc_valid,
  input  logic [ADC_W-1:0]                      adc_left,
  input  logic [ADC_W-1:0]                      adc_right,
  output tag_word_t                             tag_q,
  output logic [DATA_SLOTS-1:0][SLOT_W-1:0]     words_q,
  output logic                                  rd_ack
);
  // Index echo: top bit held at 0, index just below it, rest zero.
  function automatic slot_word_t addr_slot(input logic ok, input logic [IDX_W-1:0] idx);
    slot_word_t w;
    w = '0;
    if (ok) w[SLOT_W-2 -: IDX_W] = idx;
    return w;
  endfunction

  // Read data left-justified, blanked when no response rides in the frame.
  function automatic slot_word_t data_slot(input logic ok, input logic [RD_W-1:0] d);
    slot_word_t w;
    w = '0;
    if (ok) w[SLOT_W-1 -: RD_W] = d;
    return w;
  endfunction

  // Sample left-justified, low positions padded with zero.
  function automatic slot_word_t pcm_slot(input logic ok, input logic [ADC_W-1:0] s);
    slot_word_t w;
    w = '0;
    if (ok) w[SLOT_W-1 -: ADC_W] = s;
    return w;
  endfunction

  function automatic tag_word_t tag_word(input logic rdy, input logic rd_ok, input logic pcm_ok);
    tag_word_t t;
    t = '0;
    t[TAG_W-1] = rdy;
    t[TAG_W-2] = rd_ok;
    t[TAG_W-3] = rd_ok;
    t[TAG_W-4] = pcm_ok;
    t[TAG_W-5] = pcm_ok;
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q   <= '0;
      words_q <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= frame_start & rd_pending;
      if (frame_start) begin
        tag_q      <= tag_word(codec_ready, rd_pending, adc_valid);
        words_q[0] <= addr_slot(rd_pending, rd_index);
        words_q[1] <= data_slot(rd_pending, rd_data);
        words_q[2] <= pcm_slot(adc_valid, adc_left);
        words_q[3] <= pcm_slot(adc_valid, adc_right);
      end
    end
  end
endmodule

// File: rtl/cfx_bit_mux.sv
module cfx_bit_mux
  import cfx_pkg::*;
(
  input  logic                              active,
  input  slot_num_t                         slot_num,
  input  bit_pos_t                          bit_pos,
  input  tag_word_t                         tag_q,
  input  logic [DATA_SLOTS-1:0][SLOT_W-1:0] words_q,
  output logic                              sdata
);
  slot_word_t frame_words [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_word
    if (i < DATA_SLOTS) begin : g_live
      assign frame_words[i] = words_q[i];
    end else begin : g_zero
      assign frame_words[i] = '0;
    end
  end

  always_comb begin
    if (!active) begin
      sdata = 1'b0;
    end else if (slot_num == '0) begin
      sdata = tag_q[bit_pos[TAG_POS_W-1:0]];
    end else begin
      sdata = frame_words[slot_num - slot_num_t'(1)][bit_pos];
    end
  end
endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx
  import cfx_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int RD_W  = 16,
  parameter int ADC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             codec_ready,
  input  logic             rd_pending,
  input  logic [IDX_W-1:0] rd_index,
  input  logic [RD_W-1:0]  rd_data,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_left,
  input  logic [ADC_W-1:0] adc_right,
  output logic             sdata,
  output logic             rd_ack
);
  logic                              frame_start;
  logic                              frame_last;
  logic                              active;
  slot_num_t                         slot_num;
  bit_pos_t                          bit_pos;
  tag_word_t                         tag_q;
  logic [DATA_SLOTS-1:0][SLOT_W-1:0] words_q;

  cfx_frame_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync        (sync),
    .frame_start (frame_start),
    .frame_last  (frame_last),
    .active      (active),
    .slot_num    (slot_num),
    .bit_pos     (bit_pos)
  );

  cfx_slot_latch #(
    .IDX_W (IDX_W),
    .RD_W  (RD_W),
    .ADC_W (ADC_W)
  ) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .codec_ready (codec_ready),
    .rd_pending  (rd_pending),
    .rd_index    (rd_index),
    .rd_data     (rd_data),
    .adc_valid   (adc_valid),
    .adc_left    (adc_left),
    .adc_right   (adc_right),
    .tag_q       (tag_q),
    .words_q     (words_q),
    .rd_ack      (rd_ack)
  );

  cfx_bit_mux u_mux (
    .active   (active),
    .slot_num (slot_num),
    .bit_pos  (bit_pos),
    .tag_q    (tag_q),
    .words_q  (words_q),
    .sdata    (sdata)
  );
endmodule

// File: rtl/codec_frame_tx_chk.sv
module codec_frame_tx_chk
  import cfx_pkg::*;
#(
  parameter int RD_W  = 16,
  parameter int ADC_W = 18
) (
  input logic      clk,
  input logic      rst_n,
  input logic      frame_start,
  input logic      frame_last,
  input logic      active,
  input slot_num_t slot_num,
  input bit_pos_t  bit_pos,
  input logic      sdata,
  input logic      rd_ack
);
  localparam bit_pos_t DATA_PAD = bit_pos_t'(SLOT_W - RD_W);
  localparam bit_pos_t PCM_PAD  = bit_pos_t'(SLOT_W - ADC_W);

  // R1
  start_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (active && slot_num == '0 && bit_pos == TAG_TOP));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_start && bit_pos == '0 && slot_num != LAST_SLOT)
      |=> (slot_num == $past(slot_num) + slot_num_t'(1) && bit_pos == SLOT_TOP));

  // R1
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && !frame_start) |=> !active);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdata);

  // R4
  addr_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_num == SLOT_ADDR && bit_pos == SLOT_TOP) |-> !sdata);

  // R5
  data_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_num == SLOT_DATA && bit_pos < DATA_PAD) |-> !sdata);

  // R6
  pcm_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (slot_num == SLOT_LEFT || slot_num == SLOT_RIGHT) && bit_pos < PCM_PAD) |-> !sdata);

  // R7
  unused_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_num > SLOT_RIGHT) |-> !sdata);

  // R9
  ack_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(frame_start));

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);
endmodule

bind codec_frame_tx codec_frame_tx_chk #(
  .RD_W  (RD_W),
  .ADC_W (ADC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .frame_last  (frame_last),
  .active      (active),
  .slot_num    (slot_num),
  .bit_pos     (bit_pos),
  .sdata       (sdata),
  .rd_ack      (rd_ack)
);

// File: tb/sim_codec_frame_tx.sv
module sim_codec_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        codec_ready = 1'b0;
  logic        rd_pending = 1'b0;
  logic [6:0]  rd_index = '0;
  logic [15:0] rd_data = '0;
  logic        adc_valid = 1'b0;
  logic [17:0] adc_left = '0;
  logic [17:0] adc_right = '0;
  logic        sdata;
  logic        rd_ack;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  codec_frame_tx u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync        (sync),
    .codec_ready (codec_ready),
    .rd_pending  (rd_pending),
    .rd_index    (rd_index),
    .rd_data     (rd_data),
    .adc_valid   (adc_valid),
    .adc_left    (adc_left),
    .adc_right   (adc_right),
    .sdata       (sdata),
    .rd_ack      (rd_ack)
  );

  // Whole frame as a 256-bit number; frame bit k sits at position 255-k.
  function automatic logic [255:0] exp_frame(input logic rdy, input logic pend, input logic av,
                                             input logic [6:0] idx, input logic [15:0] dat,
                                             input logic [17:0] l, input logic [17:0] r);
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    tag = {rdy, pend, pend, av, av, 11'd0};
    s1  = pend ? (20'(idx) << 12) : 20'd0;
    s2  = pend ? (20'(dat) << 4)  : 20'd0;
    s3  = av   ? (20'(l) << 2)    : 20'd0;
    s4  = av   ? (20'(r) << 2)    : 20'd0;
    return {tag, s1, s2, s3, s4, 160'd0};
  endfunction

  function automatic string req_of(input int k);
    if (k == 0)  return "R2";
    if (k < 16)  return "R3";
    if (k < 36)  return "R4";
    if (k < 56)  return "R5";
    if (k < 96)  return "R6";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, sdata, 1'b0);
      chk(req, rd_ack, 1'b0);
    end
  endtask

  // Starts a frame, checks its first nbits bits; optionally flips all inputs mid-frame (R8).
  task automatic run_frame(input logic rdy, input logic pend, input logic av,
                           input logic [6:0] idx, input logic [15:0] dat,
                           input logic [17:0] l, input logic [17:0] r,
                           input int nbits, input bit disturb);
    logic [255:0] f;
    f = exp_frame(rdy, pend, av, idx, dat, l, r);
    @(negedge clk);
    codec_ready = rdy; rd_pending = pend; adc_valid = av;
    rd_index = idx; rd_data = dat; adc_left = l; adc_right = r;
    sync = 1'b1;
    for (int k = 0; k < nbits; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb && k > 30) chk("R8", sdata, f[255-k]);
      else                   chk(req_of(k), sdata, f[255-k]);
      if (k == 0) chk("R9", rd_ack, pend);
      if (k == 1) chk("R9", rd_ack, 1'b0);
      if (k == 15) sync = 1'b0;
      if (disturb && k == 30) begin
        codec_ready = ~codec_ready; rd_pending = ~rd_pending; adc_valid = ~adc_valid;
        rd_index = ~rd_index; rd_data = ~rd_data; adc_left = ~adc_left; adc_right = ~adc_right;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R1 watchdog: got no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset holds the line quiet even with sync high
    sync = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", sdata, 1'b0);
      chk("R10", rd_ack, 1'b0);
    end
    sync = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle_check(5, "R10");

    // Sweep all flag combinations with varied payloads
    for (int c = 0; c < 8; c++) begin
      run_frame(c[0], c[1], c[2], 7'(c * 17 + 5), 16'hA5C3 ^ 16'(c * 16'h1111),
                18'h25A5A ^ 18'(c << 9), ~(18'h25A5A ^ 18'(c << 9)), 256, c[0]);
      idle_check(3, "R1");
    end

    // Extremes: all-ones payload exposes pad bits, all-zero payload
    run_frame(1'b1, 1'b1, 1'b1, 7'h7F, 16'hFFFF, 18'h3FFFF, 18'h3FFFF, 256, 1'b0);
    idle_check(2, "R1");
    run_frame(1'b1, 1'b1, 1'b1, 7'h00, 16'h0000, 18'h00000, 18'h3FFFF, 256, 1'b0);
    idle_check(2, "R1");
    run_frame(1'b1, 1'b1, 1'b1, 7'h40, 16'h8001, 18'h20001, 18'h00001, 256, 1'b1);
    idle_check(2, "R1");

    // R1: sync rise mid-frame restarts on the new contents
    run_frame(1'b1, 1'b0, 1'b1, 7'h11, 16'h1234, 18'h12345, 18'h2ABCD, 120, 1'b0);
    run_frame(1'b0, 1'b1, 1'b0, 7'h2C, 16'hBEEF, 18'h3C3C3, 18'h05050, 256, 1'b0);
    idle_check(4, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule